// File: doc/BRIEF.md
# Programmable Interrupt Controller with Fast and Normal Request Classes

This block gathers a set of interrupt request lines and conditions each one on its own terms before it reaches the processor. Software picks the sense of each line (asserted high or asserted low) and how it is detected (as a level, or as a captured transition). It also decides whether the line is allowed through, and whether it raises the fast request or the normal request. Captured transitions stay held until software clears them by writing ones to a clear register.

Software can observe every stage of the chain through a flat 32-bit register port: the sampled raw inputs, the conditioned active state, the enabled status, the enabled status split by class, and for each class the index of the lowest-numbered pending line. Two active-low request outputs, one per class, go to the processor. Vectoring and nesting are handled elsewhere.

Top module: `intr_ctrl`

## Requirements
- R1: The raw-source register (offset 0x00) reads the request lines as sampled by one register stage.
- R2: Polarity bit = 1 makes a line active when high; bit = 0 makes it active when low. With trigger bit 0 (level mode), active-register bit (0x08) equals that conditioned level.
- R3: Trigger bit = 1 (edge mode) sets a per-line latch when the conditioned level rises from inactive to active. The active-register bit then shows the latch, and the latch stays set after the input goes back to inactive.
- R4: Writing the clear register (0x10) clears exactly the latches whose data bits are 1. Zero bits have no effect, and the clear register reads 0.
- R5: The status register (0x18) reads active AND enable (0x14), where enable bit 1 passes the line.
- R6: Class bit (0x1C) 0 routes a line to the normal class and 1 to the fast class. Fast status (0x20) reads status AND class, and normal status (0x24) reads status AND NOT class.
- R7: The fast-index (0x28) and normal-index (0x2C) registers give the lowest-numbered set bit of the matching class status. They read all ones (0xFFFFFFFF) when that status is zero.
- R8: fiq_n_o and irq_n_o are low one clock after their class status is non-zero, and high one clock after it is zero.
- R9: Polarity (0x04), trigger (0x0C), enable (0x14) and class (0x1C) are written on word-aligned writes and read back. Writes to read-only offsets change nothing.
- R10: After reset, the polarity, trigger, enable and class registers and all edge latches are zero, both request outputs are high, and both index registers read all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | N_LINES | Raw interrupt request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| fiq_n_o | output | 1 | Fast request, active low |
| irq_n_o | output | 1 | Normal request, active low |

## Verification
The assertions take as given that request lines are synchronous to clk, since they are sampled by a single register stage. They also assume that a latch may only drop in the cycle after a clear write has landed. The stimulus changes lines and configuration only on the falling clock edge and holds each setting for several cycles before sampling. This keeps every transition on a line a clean single-cycle step, which the reference model counts as at most one edge. Random configuration writes are mixed with directed cases for latch hold, partial clears, ignored writes and the empty-index value.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;

    // Word-index decode of the register port (byte offset = index * 4).
    typedef enum logic [3:0] {
        RS_SOURCES  = 4'd0,
        RS_POLARITY = 4'd1,
        RS_ACTIVE   = 4'd2,
        RS_TRIGGER  = 4'd3,
        RS_CLEAR    = 4'd4,
        RS_ENABLE   = 4'd5,
        RS_STATUS   = 4'd6,
        RS_CLASS    = 4'd7,
        RS_FAST_ST  = 4'd8,
        RS_NORM_ST  = 4'd9,
        RS_FAST_IDX = 4'd10,
        RS_NORM_IDX = 4'd11
    } reg_sel_e;

    localparam int unsigned REG_COUNT = 12;

endpackage

// File: rtl/intr_line_cond.sv
module intr_line_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic pol_i,
    input  logic trig_i,
    input  logic clr_i,
    output logic active_o,
    output logic edge_o
);

    typedef struct packed {
        logic prev;
        logic latch;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     lvl;

    always_comb begin
        lvl        = pol_i ? raw_i : ~raw_i;
        st_d.prev  = lvl;
        // A fresh edge wins over a clear landing in the same cycle.
        st_d.latch = (trig_i & lvl & ~st_q.prev) | (st_q.latch & ~clr_i);
        active_o   = trig_i ? st_q.latch : lvl;
        edge_o     = st_q.latch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/intr_lowest_enc.sv
module intr_lowest_enc #(
    parameter int unsigned N_IN  = 32,
    parameter int unsigned OUT_W = 32
) (
    input  logic [N_IN-1:0]  vec_i,
    output logic [OUT_W-1:0] idx_o
);

    always_comb begin
        idx_o = '1;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = OUT_W'(i);
        end
    end

endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               fiq_n_o,
    output logic               irq_n_o
);
    import intr_ctrl_pkg::*;

    localparam int unsigned SEL_W = ADDR_W - 2;

    typedef struct packed {
        logic [N_LINES-1:0] src;
        logic [N_LINES-1:0] pol;
        logic [N_LINES-1:0] trig;
        logic [N_LINES-1:0] en;
        logic [N_LINES-1:0] cls;
        logic               fiq_n;
        logic               irq_n;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [SEL_W-1:0]   sel;
    logic               aligned;
    logic               wr_hit;
    logic [N_LINES-1:0] wvec;
    logic [N_LINES-1:0] clr_w;
    logic [N_LINES-1:0] act_w;
    logic [N_LINES-1:0] edge_w;
    logic [N_LINES-1:0] stat_w;
    logic [N_LINES-1:0] fiq_stat_w;
    logic [N_LINES-1:0] irq_stat_w;
    logic [DATA_W-1:0]  fiq_idx_w;
    logic [DATA_W-1:0]  irq_idx_w;

    assign sel     = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign wr_hit  = bus_wr_i && aligned;
    assign wvec    = bus_wdata_i[N_LINES-1:0];
    assign clr_w   = (wr_hit && sel == SEL_W'(RS_CLEAR)) ? wvec : '0;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        intr_line_cond u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (st_q.src[g]),
            .pol_i    (st_q.pol[g]),
            .trig_i   (st_q.trig[g]),
            .clr_i    (clr_w[g]),
            .active_o (act_w[g]),
            .edge_o   (edge_w[g])
        );
    end

    assign stat_w     = act_w & st_q.en;
    assign fiq_stat_w = stat_w & st_q.cls;
    assign irq_stat_w = stat_w & ~st_q.cls;

    intr_lowest_enc #(.N_IN(N_LINES), .OUT_W(DATA_W)) u_fiq_enc (
        .vec_i (fiq_stat_w),
        .idx_o (fiq_idx_w)
    );

    intr_lowest_enc #(.N_IN(N_LINES), .OUT_W(DATA_W)) u_irq_enc (
        .vec_i (irq_stat_w),
        .idx_o (irq_idx_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.src   = lines_i;
        st_d.fiq_n = ~(|fiq_stat_w);
        st_d.irq_n = ~(|irq_stat_w);
        if (wr_hit) begin
            case (sel)
                SEL_W'(RS_POLARITY): st_d.pol  = wvec;
                SEL_W'(RS_TRIGGER):  st_d.trig = wvec;
                SEL_W'(RS_ENABLE):   st_d.en   = wvec;
                SEL_W'(RS_CLASS):    st_d.cls  = wvec;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fiq_n <= 1'b1;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            case (sel)
                SEL_W'(RS_SOURCES):  bus_rdata_o = DATA_W'(st_q.src);
                SEL_W'(RS_POLARITY): bus_rdata_o = DATA_W'(st_q.pol);
                SEL_W'(RS_ACTIVE):   bus_rdata_o = DATA_W'(act_w);
                SEL_W'(RS_TRIGGER):  bus_rdata_o = DATA_W'(st_q.trig);
                SEL_W'(RS_ENABLE):   bus_rdata_o = DATA_W'(st_q.en);
                SEL_W'(RS_STATUS):   bus_rdata_o = DATA_W'(stat_w);
                SEL_W'(RS_CLASS):    bus_rdata_o = DATA_W'(st_q.cls);
                SEL_W'(RS_FAST_ST):  bus_rdata_o = DATA_W'(fiq_stat_w);
                SEL_W'(RS_NORM_ST):  bus_rdata_o = DATA_W'(irq_stat_w);
                SEL_W'(RS_FAST_IDX): bus_rdata_o = fiq_idx_w;
                SEL_W'(RS_NORM_IDX): bus_rdata_o = irq_idx_w;
                default:             bus_rdata_o = '0;
            endcase
        end
    end

    assign fiq_n_o = st_q.fiq_n;
    assign irq_n_o = st_q.irq_n;

endmodule

// File: rtl/intr_ctrl_chk.sv
module intr_ctrl_chk #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [N_LINES-1:0] en_vec,
    input logic [N_LINES-1:0] edge_vec,
    input logic [N_LINES-1:0] stat_vec,
    input logic [N_LINES-1:0] fiq_vec,
    input logic [N_LINES-1:0] irq_vec,
    input logic [DATA_W-1:0]  fiq_idx,
    input logic               fiq_n_o,
    input logic               irq_n_o
);

    logic clr_wr;
    assign clr_wr = bus_wr_i && (bus_addr_i == ADDR_W'(16));

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_wr) |-> ((edge_vec & $past(edge_vec)) == $past(edge_vec))); // R3

    AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec & ~en_vec) == '0); // R5

    AST_CLASS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((fiq_vec & irq_vec) == '0) && ((fiq_vec | irq_vec) == stat_vec)); // R6

    AST_IDX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_vec == '0) == (fiq_idx == '1)); // R7

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_vec != '0) |-> (fiq_vec[fiq_idx[$clog2(N_LINES)-1:0]] &&
        ((fiq_vec & ((N_LINES'(1) << fiq_idx[$clog2(N_LINES)-1:0]) - N_LINES'(1))) == '0))); // R7

    AST_FAST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_vec != '0) |=> !fiq_n_o); // R8

    AST_NORM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec == '0) |=> irq_n_o); // R8

endmodule

bind intr_ctrl intr_ctrl_chk #(.N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .en_vec     (st_q.en),
    .edge_vec   (edge_w),
    .stat_vec   (stat_w),
    .fiq_vec    (fiq_stat_w),
    .irq_vec    (irq_stat_w),
    .fiq_idx    (fiq_idx_w),
    .fiq_n_o    (fiq_n_o),
    .irq_n_o    (irq_n_o)
);

// File: tb/intr_ctrl_bench.sv
module intr_ctrl_bench;

    localparam logic [5:0] A_SRC = 6'h00, A_POL = 6'h04, A_ACT = 6'h08, A_TRG = 6'h0C,
                           A_CLR = 6'h10, A_EN  = 6'h14, A_STA = 6'h18, A_CLS = 6'h1C,
                           A_FST = 6'h20, A_NST = 6'h24, A_FIX = 6'h28, A_NIX = 6'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq_n, irq_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] m_src = '0, m_pol = '0, m_trg = '0, m_en = '0, m_cls = '0;
    logic [31:0] m_lvl = '1, m_edge = '0;

    always #10 clk = ~clk;

    intr_ctrl u_intr_ctrl (
        .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_n_o(fiq_n), .irq_n_o(irq_n)
    );

    function automatic logic [31:0] lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
        return '1;
    endfunction

    function automatic logic [31:0] m_act();
        return (m_trg & m_edge) | (~m_trg & m_lvl);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Recompute conditioned level and record any rising edge on edge-mode lines.
    task automatic model_step();
        logic [31:0] nl;
        nl     = ~(m_src ^ m_pol);
        m_edge = m_edge | (m_trg & nl & ~m_lvl);
        m_lvl  = nl;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        case (a)
            A_POL: m_pol = d;
            A_TRG: m_trg = d;
            A_EN:  m_en  = d;
            A_CLS: m_cls = d;
            A_CLR: m_edge = m_edge & ~d;
            default: ;
        endcase
        model_step();
        settle();
    endtask

    task automatic drive_lines(input logic [31:0] v);
        @(negedge clk);
        lines = v;
        m_src = v;
        model_step();
        settle();
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #2 d = rdata;
    endtask

    task automatic check_all();
        logic [31:0] d, st;
        st = m_act() & m_en;
        bus_read(A_SRC, d); check("R1 sources", d, m_src);
        bus_read(A_POL, d); check("R9 polarity", d, m_pol);
        bus_read(A_ACT, d); check("R2/R3 active", d, m_act());
        bus_read(A_TRG, d); check("R9 trigger", d, m_trg);
        bus_read(A_CLR, d); check("R4 clear reads zero", d, 32'h0);
        bus_read(A_EN,  d); check("R9 enable", d, m_en);
        bus_read(A_STA, d); check("R5 status", d, st);
        bus_read(A_CLS, d); check("R9 class", d, m_cls);
        bus_read(A_FST, d); check("R6 fast status", d, st & m_cls);
        bus_read(A_NST, d); check("R6 normal status", d, st & ~m_cls);
        bus_read(A_FIX, d); check("R7 fast index", d, lowest(st & m_cls));
        bus_read(A_NIX, d); check("R7 normal index", d, lowest(st & ~m_cls));
        check("R8 fiq_n", {31'b0, fiq_n}, {31'b0, ~|(st & m_cls)});
        check("R8 irq_n", {31'b0, irq_n}, {31'b0, ~|(st & ~m_cls)});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0C1A));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle();

        // R10: reset state
        check("R10 fiq_n high", {31'b0, fiq_n}, 32'h1);
        check("R10 irq_n high", {31'b0, irq_n}, 32'h1);
        bus_read(A_NIX, d); check("R10 index empty", d, 32'hFFFF_FFFF);
        check_all();

        // R2: active-low level lines
        drive_lines(32'hFFFF_FFF0);
        bus_read(A_ACT, d); check("R2 active low", d, 32'h0000_000F);
        bus_write(A_POL, 32'hFFFF_FFFF);
        bus_read(A_ACT, d); check("R2 active high", d, 32'hFFFF_FFF0);

        // R9: writes to read-only registers are ignored
        bus_write(A_EN, 32'h0000_00F0);
        bus_write(A_STA, 32'h0000_0000);
        bus_write(A_SRC, 32'h1234_5678);
        bus_read(A_STA, d); check("R9 status write ignored", d, 32'h0000_00F0);
        bus_read(A_SRC, d); check("R9 sources write ignored", d, 32'hFFFF_FFF0);
        check_all();

        // R3/R4: edge latch holds, partial clear, zero clear
        drive_lines(32'h0);
        bus_write(A_TRG, 32'h0000_0030);
        bus_write(A_EN, 32'hFFFF_FFFF);
        drive_lines(32'h0000_0030);
        drive_lines(32'h0);
        bus_read(A_ACT, d); check("R3 latch holds", d, 32'h0000_0030);
        bus_write(A_CLR, 32'h0);
        bus_read(A_ACT, d); check("R4 zero clear no effect", d, 32'h0000_0030);
        bus_write(A_CLR, 32'h0000_0010);
        bus_read(A_ACT, d); check("R4 partial clear", d, 32'h0000_0020);

        // R6/R7/R8: classes and indices at the extremes
        bus_write(A_TRG, 32'h0);
        bus_write(A_CLS, 32'h8000_0000);
        drive_lines(32'h8000_0001);
        bus_read(A_FIX, d); check("R7 fast index 31", d, 32'd31);
        bus_read(A_NIX, d); check("R7 normal index 0", d, 32'd0);
        check("R8 both asserted", {30'b0, fiq_n, irq_n}, 32'h0);
        check_all();

        // Random mix
        for (int it = 0; it < 80; it++) begin
            case ($urandom % 6)
                0: drive_lines($urandom);
                1: bus_write(A_POL, $urandom);
                2: bus_write(A_TRG, $urandom);
                3: bus_write(A_EN, $urandom | $urandom);
                4: bus_write(A_CLS, $urandom);
                default: bus_write(A_CLR, $urandom);
            endcase
            check_all();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule